// File: doc/BRIEF.md
# Call Progress Tone Classifier

This block sorts a telephone line's call progress tone into one of five classes by watching a one-bit envelope signal. The envelope is high while tone energy is present. When the envelope rises while the block is idle, the block opens a fixed decision window. It counts every change of the envelope inside that window. When the window closes, it turns the count into a 3-bit class code, holds that code in an output latch and raises a data-valid flag.

A host sends a clear pulse once dialing is over. It then waits for data-valid and reads the code while the output enable is high. Pulling enable low puts the code and data-valid pins in high impedance and drops the data-valid flag. A held result stays in place until the next clear. The result interface is a plain level: there is no handshake and no back-pressure. The code stays in the latch until the host clears it, so no result is ever lost.

The envelope and clear inputs are asynchronous, and each passes through a two-flop synchroniser. The window length is a cycle count. Its default is 8,234,000 cycles, which is 2.3 s at a 3.58 MHz clock. Four parameters set the count thresholds between the classes.

Top module: `cp_tone_classifier`

## Requirements
- R1: A rising edge of the synchronised envelope while the block is idle and clear is low starts a window of WINDOW_CYCLES cycles. The result and data-valid appear WINDOW_CYCLES+3 clock edges after the envelope pin changes: two synchroniser stages plus one edge to enter the window.
- R2: Both rising and falling envelope edges inside the window add one to the count. The edge that opens the window does not count. A steady tone gives a count of 0 and code 000 (dial tone).
- R3: The code, written {code_out[2], code_out[1], code_out[0]}, maps the count as follows: 0 gives 000, RING_MIN (1) to BUSY_MIN-1 (2) give 100 (ringing), BUSY_MIN (3) to REORDER_MIN-1 (6) give 010 (busy), and REORDER_MIN (7) to OVF_MIN-1 (11) give 001 (re-order).
- R4: A tone that is high at the start of the window and ends inside it gives one falling edge. It is therefore reported as ringing, code 100.
- R5: A count of OVF_MIN (12) or more gives 111 (overflow). The counter saturates at OVF_MIN and does not wrap, so 15 edges still give 111.
- R6: Once a result is latched, envelope activity changes neither the code nor data-valid until the next clear.
- R7: When clear goes high, the window, the counter, the code latch (000) and data-valid (0) are all reset. While clear stays high, no window starts. After clear falls, a new window needs a fresh rising edge of the envelope.
- R8: While oe_in is low, code_out and dv_out are high impedance and the internal data-valid flag is cleared. When oe_in goes high again, the held code shows and dv_out stays low.
- R9: After reset, dv_out is 0 and code_out is 000 while oe_in is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Active-low reset |
| env_in | input | 1 | Tone envelope level, asynchronous |
| clear_in | input | 1 | Clear pulse, asynchronous, active high |
| oe_in | input | 1 | Output enable; low gives high impedance and clears data-valid |
| code_out | output | 3 | Class code {bit3, bit2, bit1} |
| dv_out | output | 1 | Result valid |

## Verification
A window result is due WINDOW_CYCLES+3 edges after the envelope pin changes. The bench drives its inputs on falling edges and counts falling edges from that drive. It checks that data-valid is still low one edge before the result is due, and checks the code and data-valid exactly on the edge where they are due. Clear takes effect two edges after the pin changes, through its synchroniser, so the bench samples four edges after a clear pulse. The output enable acts on the pins with no register in the path, so the bench checks the pins on the same falling edge where it changes enable.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_DONE   = 2'd2
  } ctc_state_e;

  localparam logic [2:0] CODE_DIAL    = 3'b000;
  localparam logic [2:0] CODE_RING    = 3'b100;
  localparam logic [2:0] CODE_BUSY    = 3'b010;
  localparam logic [2:0] CODE_REORDER = 3'b001;
  localparam logic [2:0] CODE_OVF     = 3'b111;
endpackage

// File: rtl/ctc_sync.sv
module ctc_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/ctc_edge_counter.sv
module ctc_edge_counter #(
  parameter int SAT = 12,
  localparam int CNT_W = $clog2(SAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             toggle,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_nxt
);
  localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(SAT);

  always_comb begin
    if (clr) begin
      count_nxt = '0;
    end else if (en && toggle && (count_q != SAT_VAL)) begin
      count_nxt = count_q + 1'b1;
    end else begin
      count_nxt = count_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_nxt;
  end
endmodule

// File: rtl/ctc_window_timer.sv
module ctc_window_timer #(
  parameter int CYCLES = 8_234_000,
  localparam int TMR_W = $clog2(CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic             running,
  output logic [TMR_W-1:0] timer_q,
  output logic             expire
);
  localparam logic [TMR_W-1:0] LAST = TMR_W'(CYCLES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
    end else if (clr || start) begin
      timer_q <= '0;
    end else if (running) begin
      timer_q <= timer_q + 1'b1;
    end
  end

  assign expire = running && (timer_q == LAST);
endmodule

// File: rtl/ctc_classifier.sv
module ctc_classifier #(
  parameter int RING_MIN    = 1,
  parameter int BUSY_MIN    = 3,
  parameter int REORDER_MIN = 7,
  parameter int OVF_MIN     = 12,
  localparam int CNT_W = $clog2(OVF_MIN + 1)
) (
  input  logic [CNT_W-1:0] count,
  output logic [2:0]       code
);
  import ctc_pkg::*;

  always_comb begin
    if (count >= CNT_W'(OVF_MIN))          code = CODE_OVF;
    else if (count >= CNT_W'(REORDER_MIN)) code = CODE_REORDER;
    else if (count >= CNT_W'(BUSY_MIN))    code = CODE_BUSY;
    else if (count >= CNT_W'(RING_MIN))    code = CODE_RING;
    else                                   code = CODE_DIAL;
  end
endmodule

// File: rtl/cp_tone_classifier.sv
module cp_tone_classifier #(
  parameter int WINDOW_CYCLES = 8_234_000,
  parameter int RING_MIN      = 1,
  parameter int BUSY_MIN      = 3,
  parameter int REORDER_MIN   = 7,
  parameter int OVF_MIN       = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       env_in,
  input  logic       clear_in,
  input  logic       oe_in,
  output wire  [2:0] code_out,
  output wire        dv_out
);
  import ctc_pkg::*;

  localparam int CNT_W = $clog2(OVF_MIN + 1);
  localparam int TMR_W = $clog2(WINDOW_CYCLES + 1);

  logic [1:0]       sync_vec;
  logic             env_s;
  logic             clear_s;
  logic             env_d;
  ctc_state_e       state_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_nxt;
  logic [TMR_W-1:0] timer_q;
  logic             expire;
  logic             start;
  logic [2:0]       code_nxt;
  logic [2:0]       code_q;
  logic             valid_q;

  ctc_sync #(.WIDTH(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({clear_in, env_in}),
    .sync_out (sync_vec)
  );
  assign env_s   = sync_vec[0];
  assign clear_s = sync_vec[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) env_d <= 1'b0;
    else        env_d <= env_s;
  end

  assign start = (state_q == ST_IDLE) && !clear_s && env_s && !env_d;

  ctc_edge_counter #(.SAT(OVF_MIN)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clear_s || (state_q == ST_IDLE)),
    .en        (state_q == ST_WINDOW),
    .toggle    (env_s ^ env_d),
    .count_q   (count_q),
    .count_nxt (count_nxt)
  );

  ctc_window_timer #(.CYCLES(WINDOW_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clear_s),
    .start   (start),
    .running (state_q == ST_WINDOW),
    .timer_q (timer_q),
    .expire  (expire)
  );

  ctc_classifier #(
    .RING_MIN    (RING_MIN),
    .BUSY_MIN    (BUSY_MIN),
    .REORDER_MIN (REORDER_MIN),
    .OVF_MIN     (OVF_MIN)
  ) u_cls (
    .count (count_nxt),
    .code  (code_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= CODE_DIAL;
      valid_q <= 1'b0;
    end else if (clear_s) begin
      state_q <= ST_IDLE;
      code_q  <= CODE_DIAL;
      valid_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) state_q <= ST_WINDOW;
        end
        ST_WINDOW: begin
          if (expire) begin
            state_q <= ST_DONE;
            code_q  <= code_nxt;
            valid_q <= oe_in;
          end
        end
        ST_DONE: begin
          valid_q <= valid_q & oe_in;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign code_out = oe_in ? code_q  : 3'bzzz;
  assign dv_out   = oe_in ? valid_q : 1'bz;
endmodule

// File: rtl/ctc_checker.sv
module ctc_checker #(
  parameter int WINDOW_CYCLES = 8_234_000,
  parameter int OVF_MIN       = 12,
  localparam int CNT_W = $clog2(OVF_MIN + 1),
  localparam int TMR_W = $clog2(WINDOW_CYCLES + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                oe_in,
  input logic                clear_s,
  input logic                env_s,
  input logic                env_d,
  input ctc_pkg::ctc_state_e state_q,
  input logic [TMR_W-1:0]    timer_q,
  input logic [CNT_W-1:0]    count_q,
  input logic [2:0]          code_q,
  input logic                valid_q
);
  import ctc_pkg::*;

  // R1
  window_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !clear_s && env_s && !env_d) |=> (state_q == ST_WINDOW));

  // R1
  result_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> ($past(state_q) == ST_WINDOW && $past(timer_q) == TMR_W'(WINDOW_CYCLES - 1)));

  // R3
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(code_q) || code_q == CODE_OVF));

  // R5
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q <= CNT_W'(OVF_MIN)));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && !clear_s) |=> (state_q == ST_DONE && $stable(code_q)));

  // R7
  clear_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_s |=> (state_q == ST_IDLE && !valid_q && code_q == CODE_DIAL));

  // R8
  oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_in |=> !valid_q);
endmodule

bind cp_tone_classifier ctc_checker #(
  .WINDOW_CYCLES (WINDOW_CYCLES),
  .OVF_MIN       (OVF_MIN)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .oe_in   (oe_in),
  .clear_s (clear_s),
  .env_s   (env_s),
  .env_d   (env_d),
  .state_q (state_q),
  .timer_q (timer_q),
  .count_q (count_q),
  .code_q  (code_q),
  .valid_q (valid_q)
);

// File: tb/cp_tone_classifier_bench.sv
module cp_tone_classifier_bench;
  localparam int W = 300;
  localparam int NVEC = 9;
  localparam int TOG [NVEC] = '{0, 1, 2, 3, 6, 7, 11, 12, 15};
  localparam logic [2:0] EXP [NVEC] =
    '{3'b000, 3'b100, 3'b100, 3'b010, 3'b010, 3'b001, 3'b001, 3'b111, 3'b111};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic env_in = 1'b0;
  logic clear_in = 1'b0;
  logic oe_in = 1'b1;
  wire [2:0] code_out;
  wire       dv_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cp_tone_classifier #(.WINDOW_CYCLES(W)) u_cp_tone_classifier (
    .clk      (clk),
    .rst_n    (rst_n),
    .env_in   (env_in),
    .clear_in (clear_in),
    .oe_in    (oe_in),
    .code_out (code_out),
    .dv_out   (dv_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear_in = 1'b1;
    @(negedge clk); clear_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Opens a window with a rising edge, then toggles n times.
  task automatic run_window(input int n, input logic [2:0] exp, input string req);
    @(negedge clk); env_in = 1'b1;
    for (int i = 1; i <= W + 3; i++) begin
      @(negedge clk);
      if (i >= 20 && i < 20 + 10 * n && ((i - 20) % 10 == 0)) env_in = ~env_in;
      if (i == W + 2) chk(dv_out === 1'b0, {req, " R1 early"}, dv_out, 0);
      if (i == W + 3) begin
        chk(dv_out === 1'b1, {req, " R1 due"}, dv_out, 1);
        chk(code_out === exp, req, code_out, exp);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dv_out === 1'b0, "R9 dv", dv_out, 0);
    chk(code_out === 3'b000, "R9 code", code_out, 0);

    for (int v = 0; v < NVEC; v++) begin
      run_window(TOG[v], EXP[v], (TOG[v] == 0) ? "R2" :
                 (TOG[v] == 1) ? "R4" : (TOG[v] >= 12) ? "R5" : "R3");
      // R6: envelope activity after the result
      for (int k = 0; k < 6; k++) begin
        repeat (5) @(negedge clk);
        env_in = ~env_in;
      end
      repeat (5) @(negedge clk);
      chk(code_out === EXP[v], "R6 code", code_out, EXP[v]);
      chk(dv_out === 1'b1, "R6 dv", dv_out, 1);
      env_in = 1'b0;
      pulse_clear();
      chk(dv_out === 1'b0, "R7 dv", dv_out, 0);
      chk(code_out === 3'b000, "R7 code", code_out, 0);
    end

    // R7: clear held high blocks a window
    @(negedge clk); clear_in = 1'b1;
    repeat (4) @(negedge clk);
    env_in = 1'b1;
    repeat (W + 10) @(negedge clk);
    chk(dv_out === 1'b0, "R7 held", dv_out, 0);
    clear_in = 1'b0;
    repeat (W + 10) @(negedge clk);
    chk(dv_out === 1'b0, "R7 no fresh edge", dv_out, 0);
    env_in = 1'b0;
    repeat (4) @(negedge clk);

    // R7: clear in mid-window abandons it
    @(negedge clk); env_in = 1'b1;
    repeat (100) @(negedge clk);
    env_in = 1'b0;
    pulse_clear();
    repeat (W + 10) @(negedge clk);
    chk(dv_out === 1'b0, "R7 mid-window", dv_out, 0);
    chk(code_out === 3'b000, "R7 mid-window code", code_out, 0);

    // R8: enable low
    run_window(12, 3'b111, "R5");
    @(negedge clk); oe_in = 1'b0;
    #1;
    chk(dv_out !== 1'b1, "R8 dv off", dv_out, 0);
    chk(code_out !== 3'b111, "R8 code off", code_out, 0);
    repeat (3) @(negedge clk);
    oe_in = 1'b1;
    #1;
    chk(code_out === 3'b111, "R8 code back", code_out, 7);
    chk(dv_out === 1'b0, "R8 dv stays low", dv_out, 0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule